// File: doc/BRIEF.md
# Nonvolatile Memory Power-Up Strobe Guard

This block sits between a host memory controller and an asynchronous nonvolatile memory. It holds the memory's chip-enable and write-enable strobes inactive (high) whenever the supply is not valid. After the supply becomes valid, it keeps them inactive for a fixed startup interval, so that the memory has settled before any access begins. Two comparator flags from outside tell it whether the supply is above its minimum operating level and whether it has dropped below the write-inhibit threshold. Both flags are taken as synchronous to `clk`.

A three-state machine controls the strobes: idle, counting and released. While idle or counting, the strobes stay high whatever the host requests. Once released, the host's strobes pass straight through, and a ready pin tells the host that it may access the memory. A brownout sends the machine back to idle. The whole interval must then run again before the next release. The interval is set in microseconds and the block turns it into clock cycles from the clock frequency. All pins are plain control levels, so there is no handshake at the block's edge.

Top module: `nvm_pwrup_guard`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release with supply flags bad, `ready` is 0 and both `mem_ce_n` and `mem_we_n` are 1, whatever the host strobes are.
- R2: Whenever `ready` is 0, `mem_ce_n` and `mem_we_n` are both 1, whatever `host_ce_n` and `host_we_n` are.
- R3: The supply counts as good when `supply_ok` is 1 and `supply_low` is 0. Take the clock edge that first samples the supply as good in the idle state. The machine counts from that edge, and `ready` rises at exactly the STARTUP_CYCLES-th edge after it, provided the supply stays good. Before that edge, `ready` stays 0.
- R4: While `ready` is 1 and `supply_low` is 0, `mem_ce_n` equals `host_ce_n` and `mem_we_n` equals `host_we_n`, combinationally, in all four combinations.
- R5: Whenever `supply_low` is 1, `mem_we_n` is 1 in the same cycle, with no clock edge needed, in every state.
- R6: If the supply is sampled as not good while counting or released, the next edge returns the machine to idle. Either `supply_ok` at 0 or `supply_low` at 1 counts as not good. After that edge, `ready` is 0 and both strobes are 1.
- R7: Progress made before a brownout gives no credit. After the supply returns, the full STARTUP_CYCLES interval of R3 is counted again, whatever point the interrupted count had reached.
- R8: STARTUP_CYCLES equals CLK_HZ / 1,000,000 × STARTUP_US. The defaults are 50 MHz and 2000 µs, which give 100,000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as the power-on reset |
| supply_ok | input | 1 | Supply is above its minimum operating level |
| supply_low | input | 1 | Supply is below the write-inhibit threshold |
| host_ce_n | input | 1 | Chip enable requested by the host, active low |
| host_we_n | input | 1 | Write enable requested by the host, active low |
| mem_ce_n | output | 1 | Gated chip enable to the memory, active low |
| mem_we_n | output | 1 | Gated write enable to the memory, active low |
| ready | output | 1 | Memory is released for host access |

## Verification
The bench measures the release edge to the exact cycle. A counter that is off by one would let `ready` rise one cycle early or late, and the bench would see it at the neighbouring sample. It then interrupts the count at every possible point in the interval, using both supply flags in turn, and checks each time that the full interval is counted again. A design that kept its partial count, or that ignored one of the two flags, would release too early. The bench also raises `supply_low` while the memory is released and checks `mem_we_n` before the next clock edge. A design that registered the write inhibit would let one write strobe through during a sagging supply.

// File: rtl/nvm_pwrup_pkg.sv
package nvm_pwrup_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_START = 2'd1,
    PS_READY = 2'd2
  } pwr_state_e;

  function automatic logic supply_is_good(input logic above_min, input logic below_wi);
    return above_min & ~below_wi;
  endfunction

endpackage

// File: rtl/nvm_pwrup_timer.sv
module nvm_pwrup_timer #(
  parameter int unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CLEAR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R7

endmodule

// File: rtl/nvm_pwrup_fsm.sv
module nvm_pwrup_fsm
  import nvm_pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_good,
  input  logic       timer_done,
  output pwr_state_e state
);
  pwr_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_OFF:   if (supply_good) state_nx = PS_START;
      PS_START: begin
        if (!supply_good)    state_nx = PS_OFF;
        else if (timer_done) state_nx = PS_READY;
      end
      PS_READY: if (!supply_good) state_nx = PS_OFF;
      default:  state_nx = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= state_nx;
  end

  AST_LOSS_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_OFF && !supply_good) |=> (state == PS_OFF)); // R6

  AST_READY_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_READY && $past(state) != PS_READY) |-> $past(timer_done)); // R3

endmodule

// File: rtl/nvm_pwrup_gate.sv
module nvm_pwrup_gate
  import nvm_pwrup_pkg::*;
(
  input  pwr_state_e state,
  input  logic       supply_low,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       ready
);
  logic released;

  assign released = (state == PS_READY);
  assign ready    = released;
  assign mem_ce_n = released ? host_ce_n : 1'b1;
  assign mem_we_n = (released && !supply_low) ? host_we_n : 1'b1;

endmodule

// File: rtl/nvm_pwrup_guard.sv
module nvm_pwrup_guard
  import nvm_pwrup_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned STARTUP_US = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic supply_low,
  input  logic host_ce_n,
  input  logic host_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic ready
);
  localparam int unsigned CYC_PER_US     = CLK_HZ / 1_000_000;
  localparam int unsigned STARTUP_CYCLES = (CYC_PER_US * STARTUP_US > 0) ?
                                           CYC_PER_US * STARTUP_US : 1;

  pwr_state_e state;
  logic       good;
  logic       timer_done;

  assign good = supply_is_good(supply_ok, supply_low);

  nvm_pwrup_timer #(.CYCLES(STARTUP_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == PS_START),
    .done  (timer_done)
  );

  nvm_pwrup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (good),
    .timer_done  (timer_done),
    .state       (state)
  );

  nvm_pwrup_gate u_gate (
    .state      (state),
    .supply_low (supply_low),
    .host_ce_n  (host_ce_n),
    .host_we_n  (host_we_n),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .ready      (ready)
  );

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (mem_ce_n && mem_we_n)); // R2

  AST_WRITE_BLOCKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> mem_we_n); // R5

endmodule

// File: tb/tb_nvm_pwrup_guard.sv
module tb_nvm_pwrup_guard;
  localparam int unsigned CLK_HZ     = 1_000_000;
  localparam int unsigned STARTUP_US = 20;
  localparam int unsigned N          = CLK_HZ / 1_000_000 * STARTUP_US; // R8

  logic clk = 1'b0;
  logic rst_n, supply_ok, supply_low, host_ce_n, host_we_n;
  logic mem_ce_n, mem_we_n, ready;
  int   n_run = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  nvm_pwrup_guard #(.CLK_HZ(CLK_HZ), .STARTUP_US(STARTUP_US)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_low(supply_low),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .ready(ready)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ready,ce_n,we_n} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {ready, mem_ce_n, mem_we_n};
  endfunction

  // Drive good supply from OFF and check the release lands on exactly the Nth edge after the first.
  task automatic power_up(input string tag);
    host_ce_n = 1'b0; host_we_n = 1'b0;
    supply_ok = 1'b1; supply_low = 1'b0;
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      chk({tag, " R3 hold"}, outs(), 3'b011);
    end
    @(negedge clk);
    chk({tag, " R3 release"}, outs(), 3'b100);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; supply_low = 1'b0;
    host_ce_n = 1'b0; host_we_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 3'b011);
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R1 reset overrides good supply", outs(), 3'b011);
    supply_ok = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 3'b011);

    // R2: host strobes ignored while OFF
    for (int v = 0; v < 4; v++) begin
      {host_ce_n, host_we_n} = 2'(v);
      #1 chk("R2 off sweep", outs(), 3'b011);
    end

    power_up("first");

    // R4: pass-through sweep
    for (int v = 0; v < 4; v++) begin
      {host_ce_n, host_we_n} = 2'(v);
      #1 chk("R4 pass", outs(), {1'b1, 2'(v)});
    end

    // R5: write inhibit is immediate, then R6 drops to OFF at next edge
    @(negedge clk);
    host_ce_n = 1'b0; host_we_n = 1'b0;
    supply_low = 1'b1;
    #1 chk("R5 same-cycle inhibit", outs(), 3'b101);
    @(negedge clk);
    chk("R6 low flag to OFF", outs(), 3'b011);
    supply_low = 1'b0; supply_ok = 1'b0;
    @(negedge clk);

    // R7: interrupt the count at every point, alternating flags
    for (int k = 1; k <= N; k++) begin
      supply_ok = 1'b1; supply_low = 1'b0;
      repeat (k) @(negedge clk);
      chk("R7 before cut", outs(), 3'b011);
      if (k % 2 == 0) supply_ok = 1'b0; else supply_low = 1'b1;
      @(negedge clk);
      chk("R6 cut in startup", outs(), 3'b011);
      supply_ok = 1'b0; supply_low = 1'b0;
      @(negedge clk);
      power_up("R7 rearm");
      supply_ok = 1'b0;
      @(negedge clk);
      chk("R6 ok loss in ready", outs(), 3'b011);
    end

    // R6: one-cycle good pulse never releases
    supply_ok = 1'b1;
    @(negedge clk);
    supply_ok = 1'b0;
    repeat (N + 3) @(negedge clk);
    chk("R6 glitch no release", outs(), 3'b011);

    // R5: inhibit in OFF state with host writing
    supply_low = 1'b1; supply_ok = 1'b1;
    #1 chk("R5 inhibit off", outs(), 3'b011);
    supply_low = 1'b0; supply_ok = 1'b0;
    @(negedge clk);

    // R1: reset from READY
    power_up("pre-reset");
    rst_n = 1'b0;
    #1 chk("R1 reset from ready", outs(), 3'b011);
    @(negedge clk);
    rst_n = 1'b1;
    power_up("after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule